// File: doc/BRIEF.md
# Big-Integer Multiply-Accumulate Limb Engine

This engine updates a multi-limb unsigned accumulator with the product of a limb vector and one scalar limb. The result is the accumulator plus the vector times the scalar plus a carry-in. Limbs are 64 bits wide and limb 0 is the least significant. Before a run, software loads a multiplicand vector U and an accumulator vector W through a narrow load port. A start strobe then supplies the active length, the scalar multiplier and the carry-in. When the engine finishes, the updated accumulator limbs are read back through a registered read port, and the extra top limb appears on a carry-out output.

The work runs in two passes. In the multiply pass, one lane per cycle forms the 128-bit value `U[i] * q + W[i]`. Its low 64 bits go to a scratch bank at entry `i`, and its high 64 bits go to entry `i + n`, so both halves share one scratch array. In the resolve pass, a single running carry walks the lanes from least significant upward. Each lane adds the carry to the 128-bit pair {high, low} held for that lane. The lower 64 bits of the sum are written back as the result limb, and the upper 64 bits become the next carry. The running carry is seeded from the carry-in sampled at start, and software normally passes zero. The carry left after the last lane is the carry-out limb.

Top module: `bigmac_engine`

## Requirements
- R1: After a run of length n, limbs 0..n-1 of W followed by `carry_out` as limb n equal W + U × q + carry_in as an (n+1)-limb number, computed from the values present at start. Limb i has weight 2^(64·i). n = 1 (scalar) and n = 8 are both supported.
- R2: `carry_out` holds the top limb of the last completed run. It changes only in the cycle in which `done` is high, and it is 0 after reset.
- R3: `done` is high for exactly one cycle. It rises 2·n clock edges after the edge that accepted `start`: n edges for the multiply pass and n edges for the resolve pass.
- R4: The run length n is `vlen` clamped to the range 1..MAX_LANES. A `vlen` of 0 runs one lane, and a value above MAX_LANES runs MAX_LANES lanes.
- R5: Accumulator limbs at indices n and above keep their loaded values through a run.
- R6: A `start` that arrives while a run is in progress is ignored. Its `vlen`, `mult` and `carry_in` have no effect.
- R7: A load-port write while a run is in progress is ignored.
- R8: `mult` and `carry_in` are sampled only on the edge that accepts `start`. Changing them later during the run does not alter the result.
- R9: `rd_data` shows accumulator limb `rd_idx` one clock edge after `rd_idx` is presented.
- R10: While `rst` is high, `done`, `carry_out` and `rd_data` are 0.
- R11: With `ld_en` high, `ld_bank` = 0 writes `ld_data` into U at `ld_idx`, and `ld_bank` = 1 writes it into W at `ld_idx`. A write to one vector leaves the other unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run when idle |
| vlen | input | CNT_W | Requested lane count, clamped to 1..MAX_LANES |
| mult | input | LIMB_W | Scalar multiplier limb q |
| carry_in | input | LIMB_W | Value added at lane 0 during the resolve pass |
| ld_en | input | 1 | Load-port write enable |
| ld_bank | input | 1 | Load target: 0 = U vector, 1 = W vector |
| ld_idx | input | IDX_W | Load limb index |
| ld_data | input | LIMB_W | Load limb value |
| rd_idx | input | IDX_W | Accumulator limb to read |
| rd_data | output | LIMB_W | Registered accumulator limb |
| carry_out | output | LIMB_W | Top limb of the last completed run |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that `start` is only sampled after reset has been released, and that `vlen` is stable on the accepting edge. This lets the checker clamp `vlen` itself and count the expected pass length. The assertions assume no other property of the data inputs, because the engine's timing does not depend on limb values. The stimulus applies every start and load at the falling edge and holds it for exactly one rising edge. It drives any stray start only in the middle of a run, so the cycle-count property always refers to the accepted request.

// File: rtl/bigmac_pkg.sv
package bigmac_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MUL  = 2'd1,
    ST_ADD  = 2'd2
  } bm_state_t;

  localparam logic BANK_U = 1'b0;
  localparam logic BANK_W = 1'b1;
endpackage

// File: rtl/bigmac_lane_mul.sv
module bigmac_lane_mul #(
  parameter int LIMB_W = 64
) (
  input  logic [LIMB_W-1:0] a,
  input  logic [LIMB_W-1:0] b,
  input  logic [LIMB_W-1:0] addend,
  output logic [LIMB_W-1:0] lo,
  output logic [LIMB_W-1:0] hi
);
  localparam int DW = 2 * LIMB_W;
  logic [DW-1:0] full;

  // The sum cannot exceed (2^W-1)^2 + 2^W-1, so it fits in 2W bits.
  always_comb begin
    full = DW'(a) * DW'(b) + DW'(addend);
    lo   = full[LIMB_W-1:0];
    hi   = full[DW-1:LIMB_W];
  end
endmodule

// File: rtl/bigmac_carry_add.sv
module bigmac_carry_add #(
  parameter int LIMB_W = 64
) (
  input  logic [LIMB_W-1:0] lo,
  input  logic [LIMB_W-1:0] hi,
  input  logic [LIMB_W-1:0] cin,
  output logic [LIMB_W-1:0] res,
  output logic [LIMB_W-1:0] cout
);
  localparam int DW = 2 * LIMB_W;
  logic [DW-1:0] sum;

  always_comb begin
    sum  = {hi, lo} + DW'(cin);
    res  = sum[LIMB_W-1:0];
    cout = sum[DW-1:LIMB_W];
  end
endmodule

// File: rtl/bigmac_engine.sv
module bigmac_engine
  import bigmac_pkg::*;
#(
  parameter  int LIMB_W    = 64,
  parameter  int MAX_LANES = 8,
  localparam int IDX_W     = (MAX_LANES > 1) ? $clog2(MAX_LANES) : 1,
  localparam int CNT_W     = $clog2(MAX_LANES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CNT_W-1:0]  vlen,
  input  logic [LIMB_W-1:0] mult,
  input  logic [LIMB_W-1:0] carry_in,
  input  logic              ld_en,
  input  logic              ld_bank,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [LIMB_W-1:0] ld_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [LIMB_W-1:0] rd_data,
  output logic [LIMB_W-1:0] carry_out,
  output logic              done
);
  localparam int BIDX_W = IDX_W + 1;
  localparam int BANK_N = 2 * MAX_LANES;

  bm_state_t         state;
  logic [CNT_W-1:0]  n_len;
  logic [CNT_W-1:0]  n_eff;
  logic [IDX_W-1:0]  lane;
  logic [LIMB_W-1:0] q_r;
  logic [LIMB_W-1:0] cin_r;
  logic [LIMB_W-1:0] run_c;

  logic [LIMB_W-1:0] u_mem   [MAX_LANES];
  logic [LIMB_W-1:0] w_mem   [MAX_LANES];
  logic [LIMB_W-1:0] tmp_bank[BANK_N];

  logic [BIDX_W-1:0] hi_idx;
  logic              last_lane;
  logic [LIMB_W-1:0] mul_lo, mul_hi;
  logic [LIMB_W-1:0] add_res, add_cout;

  // Clamp the requested length into 1..MAX_LANES
  always_comb begin
    if (vlen == '0)
      n_eff = CNT_W'(1);
    else if (vlen > CNT_W'(MAX_LANES))
      n_eff = CNT_W'(MAX_LANES);
    else
      n_eff = vlen;
  end

  assign hi_idx    = BIDX_W'(lane) + BIDX_W'(n_len);
  assign last_lane = (BIDX_W'(lane) == (BIDX_W'(n_len) - BIDX_W'(1)));

  bigmac_lane_mul #(.LIMB_W(LIMB_W)) u_mul (
    .a      (u_mem[lane]),
    .b      (q_r),
    .addend (w_mem[lane]),
    .lo     (mul_lo),
    .hi     (mul_hi)
  );

  bigmac_carry_add #(.LIMB_W(LIMB_W)) u_add (
    .lo   (tmp_bank[lane]),
    .hi   (tmp_bank[hi_idx]),
    .cin  (run_c),
    .res  (add_res),
    .cout (add_cout)
  );

  // Control
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      n_len     <= CNT_W'(1);
      lane      <= '0;
      q_r       <= '0;
      cin_r     <= '0;
      run_c     <= '0;
      carry_out <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            n_len <= n_eff;
            q_r   <= mult;
            cin_r <= carry_in;
            lane  <= '0;
            state <= ST_MUL;
          end
        end
        ST_MUL: begin
          if (last_lane) begin
            lane  <= '0;
            run_c <= cin_r;
            state <= ST_ADD;
          end else begin
            lane <= lane + IDX_W'(1);
          end
        end
        ST_ADD: begin
          run_c <= add_cout;
          if (last_lane) begin
            carry_out <= add_cout;
            done      <= 1'b1;
            state     <= ST_IDLE;
          end else begin
            lane <= lane + IDX_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Storage: no reset, so it can map to memory primitives
  always_ff @(posedge clk) begin
    if (state == ST_IDLE && ld_en && !rst) begin
      if (ld_bank == BANK_U) u_mem[ld_idx] <= ld_data;
      else                   w_mem[ld_idx] <= ld_data;
    end else if (state == ST_ADD && !rst) begin
      w_mem[lane] <= add_res;
    end
  end

  always_ff @(posedge clk) begin
    if (state == ST_MUL && !rst) begin
      tmp_bank[BIDX_W'(lane)] <= mul_lo;
      tmp_bank[hi_idx]        <= mul_hi;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= w_mem[rd_idx];
  end
endmodule

// File: rtl/bigmac_engine_chk.sv
module bigmac_engine_chk #(
  parameter int LIMB_W    = 64,
  parameter int MAX_LANES = 8,
  parameter int CNT_W     = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [CNT_W-1:0]  vlen,
  input logic [LIMB_W-1:0] carry_out,
  input logic              done,
  input logic [LIMB_W-1:0] rd_data
);
  logic        busy_t;
  int unsigned cnt_t;
  int unsigned exp_t;

  // Track the accepted request independently of the engine's control
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_t <= 1'b0;
      cnt_t  <= 0;
      exp_t  <= 0;
    end else if (start && (!busy_t || done)) begin
      busy_t <= 1'b1;
      cnt_t  <= 0;
      if (vlen == '0)                         exp_t <= 2;
      else if (int'(vlen) > MAX_LANES)        exp_t <= 2 * MAX_LANES;
      else                                    exp_t <= 2 * int'(vlen);
    end else if (busy_t) begin
      cnt_t <= cnt_t + 1;
      if (done) busy_t <= 1'b0;
    end
  end

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R3 R4
  done_timing_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (busy_t && cnt_t == exp_t));

  // R2
  carry_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (carry_out != $past(carry_out)) |-> done);

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!done && carry_out == '0 && rd_data == '0));
endmodule

bind bigmac_engine bigmac_engine_chk #(
  .LIMB_W    (LIMB_W),
  .MAX_LANES (MAX_LANES),
  .CNT_W     (CNT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .vlen      (vlen),
  .carry_out (carry_out),
  .done      (done),
  .rd_data   (rd_data)
);

// File: tb/tb_bigmac_engine.sv
module tb_bigmac_engine;
  localparam int LW   = 64;
  localparam int ML   = 8;
  localparam int IW   = 3;
  localparam int CW   = 4;
  localparam int BIGW = LW * (ML + 2);

  logic          clk = 1'b0;
  logic          rst;
  logic          start;
  logic [CW-1:0] vlen;
  logic [LW-1:0] mult, carry_in, ld_data, rd_data, carry_out;
  logic          ld_en, ld_bank, done;
  logic [IW-1:0] ld_idx, rd_idx;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  bigmac_engine #(.LIMB_W(LW), .MAX_LANES(ML)) dut (
    .clk(clk), .rst(rst), .start(start), .vlen(vlen), .mult(mult),
    .carry_in(carry_in), .ld_en(ld_en), .ld_bank(ld_bank), .ld_idx(ld_idx),
    .ld_data(ld_data), .rd_idx(rd_idx), .rd_data(rd_data),
    .carry_out(carry_out), .done(done)
  );

  typedef struct packed {
    logic [3:0]  vl;
    logic [63:0] q;
    logic [63:0] cin;
    logic [63:0] useed;
    logic [63:0] wseed;
  } vec_t;

  localparam logic [63:0] ONES = '1;
  localparam vec_t VECS [8] = '{
    '{4'd8,  ONES, 64'd0, ONES, ONES},
    '{4'd1,  64'd3, 64'd0, 64'd5, 64'd7},
    '{4'd8,  64'd0, 64'd0, 64'h0123456789ABCDEF, 64'hFEDCBA9876543210},
    '{4'd4,  64'd1, 64'd0, ONES, 64'd1},
    '{4'd8,  64'h123456789ABCDEF1, 64'd5, 64'hA5A5A5A5A5A5A5A5, 64'h3C3C3C3C0F0F0F0F},
    '{4'd3,  ONES, ONES, 64'd0, 64'd0},
    '{4'd0,  64'd2, 64'd1, 64'h8000000000000001, ONES},
    '{4'd12, ONES, ONES, ONES, ONES}
  };

  function automatic logic [63:0] rot(logic [63:0] s, int i);
    int sh;
    sh = (8 * i) % 64;
    if (sh == 0) return s;
    return (s << sh) | (s >> (64 - sh));
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load(logic bank, int idx, logic [63:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_bank = bank; ld_idx = IW'(idx); ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic read_limb(int idx, output logic [63:0] v);
    @(negedge clk);
    rd_idx = IW'(idx);
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic do_run(vec_t v, bit poke, output int cyc);
    @(negedge clk);
    vlen = v.vl; mult = v.q; carry_in = v.cin; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 1000) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 3) begin
        // R6 R7 R8: stray start, stray load, changed operands mid-run
        start = 1'b1; vlen = 4'd1; mult = 64'h55; carry_in = 64'd7;
        ld_en = 1'b1; ld_bank = 1'b1; ld_idx = 3'd7; ld_data = 64'hDEAD;
      end
      if (poke && cyc == 4) begin
        start = 1'b0; ld_en = 1'b0;
      end
    end
  endtask

  initial begin
    #(10 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] rv;
    rst = 1'b1; start = 1'b0; vlen = '0; mult = '0; carry_in = '0;
    ld_en = 1'b0; ld_bank = 1'b0; ld_idx = '0; ld_data = '0; rd_idx = '0;
    repeat (3) @(negedge clk);
    // R10 reset values
    chk("R10 done", 64'(done), 64'd0);
    chk("R10 carry_out", carry_out, 64'd0);
    chk("R10 rd_data", rd_data, 64'd0);
    rst = 1'b0;

    // R11 bank select, R9 read latency
    load(1'b1, 0, 64'h5);
    load(1'b0, 0, 64'h99);
    read_limb(0, rv);
    chk("R11 W untouched by U write", rv, 64'h5);
    @(negedge clk);
    rd_idx = 3'd1;
    load(1'b1, 1, 64'h77);
    @(negedge clk);
    rd_idx = 3'd0;
    @(negedge clk);
    chk("R9 one-cycle read", rd_data, 64'h5);

    for (int k = 0; k < 8; k++) begin
      vec_t v;
      int n, cyc;
      logic [BIGW-1:0] ub, wb, acc;
      string tag;
      v = VECS[k];
      n = (v.vl == 0) ? 1 : ((int'(v.vl) > ML) ? ML : int'(v.vl));
      tag = (v.vl == 0 || int'(v.vl) > ML) ? "R4" : "R1";
      ub = '0; wb = '0;
      for (int i = 0; i < ML; i++) begin
        load(1'b0, i, rot(v.useed, i));
        load(1'b1, i, rot(v.wseed, i));
        if (i < n) begin
          ub = ub | (BIGW'(rot(v.useed, i)) << (64 * i));
          wb = wb | (BIGW'(rot(v.wseed, i)) << (64 * i));
        end
      end
      acc = wb + ub * BIGW'(v.q) + BIGW'(v.cin);
      do_run(v, (k == 4), cyc);
      // R3 timing, R4 clamped length
      chk("R3 done latency", 64'(cyc), 64'(2 * n));
      @(negedge clk);
      chk("R3 done width", 64'(done), 64'd0);
      // R2 top limb
      chk("R2 carry_out", carry_out, acc[64 * n +: 64]);
      for (int i = 0; i < ML; i++) begin
        read_limb(i, rv);
        if (i < n) chk(tag, rv, acc[64 * i +: 64]);
        else       chk("R5 untouched limb", rv, rot(v.wseed, i));
      end
      mult = '0; carry_in = '0;
    end

    // R2 carry_out holds between runs
    repeat (4) @(negedge clk);
    begin
      logic [BIGW-1:0] top;
      top = {ONES, ONES, ONES, ONES, ONES, ONES, ONES, ONES};
      top = top + top * BIGW'(ONES) + BIGW'(ONES);
      chk("R2 carry_out held", carry_out, top[64 * 8 +: 64]);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule